// File: doc/BRIEF.md
# Descriptor-Table DMA Engine

This block moves sector data between a local buffer and host memory by following a table of region descriptors held in memory. A one-cycle start pulse supplies the table address, the direction and the total byte count the command expects. The engine then fetches descriptors one by one. Each descriptor names a buffer address, a byte count and a last-entry flag. The engine covers each region with memory bursts, and no burst crosses a page boundary.

It shares a single memory request port with the rest of the chip. When that port reports busy at the moment a request is due, the engine waits a fixed back-off period and tries again. After the flagged last entry it compares the bytes it moved against the expected command length. It returns a done pulse when they match and an error pulse when they do not. An abort produces the error pulse through the same completion outputs. Per-direction counters record transactions, bytes and full-page transactions.

Top module: `prd_dma_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `mem_req`, `done`, `err` and `start_ign` are 0 and all six counters are 0.
- R2: The first descriptor fetch goes to the table address with bits 1:0 cleared. Each fetch has `mem_desc`=1 and `mem_len`=8. Every later fetch address is 8 above the previous one.
- R3: On the acknowledge of a fetch, the engine captures `dsc_base`, `dsc_count` and `dsc_eot` as the region address, byte count and last-entry flag.
- R4: Each burst has length min(remaining region bytes, PAGE_BYTES − (address mod PAGE_BYTES)). Consecutive bursts of a region are contiguous.
- R5: With `to_mem`=1, every burst carries `mem_we`=1, which means data goes from the buffer to memory. With `to_mem`=0, every burst carries `mem_we`=0. Fetches always carry `mem_we`=0.
- R6: `mem_req` is never high while `mem_busy` is high. If the port is busy when a request is due, the engine retries BACKOFF+1 cycles later.
- R7: After the last burst of the entry with the flag set, if the bytes moved equal `cmd_bytes`, `done` pulses for one cycle and `busy` falls in the same cycle.
- R8: If the byte count is not exhausted at the flagged entry, `err` pulses instead of `done`, and the engine goes idle.
- R9: `abort` while the engine is busy makes `err` pulse on the next cycle and returns the engine to idle.
- R10: Each completed burst adds 1 to the transaction counter and its length to the byte counter of its direction. A burst of exactly PAGE_BYTES also adds 1 to that direction's full-page counter. Fetches are not counted.
- R11: A start pulse while busy has no effect on the running transfer, and `start_ign` pulses on the next cycle.
- R12: A descriptor with byte count 0 produces no burst. The engine moves on to the next entry, or finishes if that descriptor is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| tbl_base | input | 32 | Descriptor table address |
| to_mem | input | 1 | 1: buffer to memory, 0: memory to buffer |
| cmd_bytes | input | CMD_W | Total bytes the command expects |
| abort | input | 1 | Abort the running transfer |
| mem_req | output | 1 | Memory request, one cycle per transaction |
| mem_we | output | 1 | Request writes memory |
| mem_desc | output | 1 | Request is a descriptor fetch |
| mem_addr | output | 32 | Request address |
| mem_len | output | LEN_W | Request length in bytes |
| mem_busy | input | 1 | Memory port cannot accept a request |
| mem_ack | input | 1 | Outstanding request finished |
| dsc_base | input | 32 | Fetched descriptor region address |
| dsc_count | input | DCNT_W | Fetched descriptor byte count |
| dsc_eot | input | 1 | Fetched descriptor last-entry flag |
| busy | output | 1 | Engine not idle |
| done | output | 1 | Successful completion pulse |
| err | output | 1 | Error or abort completion pulse |
| start_ign | output | 1 | Start arrived while busy |
| rd_txn | output | CNT_W | Memory-read burst count |
| rd_bytes | output | CNT_W | Memory-read byte count |
| rd_full | output | CNT_W | Memory-read full-page bursts |
| wr_txn | output | CNT_W | Memory-write burst count |
| wr_bytes | output | CNT_W | Memory-write byte count |
| wr_full | output | CNT_W | Memory-write full-page bursts |

## Verification
The assertions check every cycle that no request is raised while the port is busy and that no burst crosses a page. They also check that fetches are aligned and 8 bytes long, that no burst has zero length, that done and error never coincide and always leave the engine idle, and that aborts and ignored starts are reported on the next cycle. The following are visible only in the bench's scenarios: the exact chunk sequence through a region, the exact retry time after back-off, the skipping of empty descriptors, the choice between done and error at the end of the table, and the per-direction counter totals.

// File: rtl/prd_dma_engine.sv
module prd_dma_engine #(
  parameter int PAGE_BYTES = 4096,
  parameter int BACKOFF    = 4,
  parameter int CMD_W      = 18,
  parameter int DCNT_W     = 16,
  parameter int CNT_W      = 32,
  localparam int PG_W      = $clog2(PAGE_BYTES),
  localparam int LEN_W     = PG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       tbl_base,
  input  logic              to_mem,
  input  logic [CMD_W-1:0]  cmd_bytes,
  input  logic              abort,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_desc,
  output logic [31:0]       mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  input  logic              mem_busy,
  input  logic              mem_ack,
  input  logic [31:0]       dsc_base,
  input  logic [DCNT_W-1:0] dsc_count,
  input  logic              dsc_eot,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              start_ign,
  output logic [CNT_W-1:0]  rd_txn,
  output logic [CNT_W-1:0]  rd_bytes,
  output logic [CNT_W-1:0]  rd_full,
  output logic [CNT_W-1:0]  wr_txn,
  output logic [CNT_W-1:0]  wr_bytes,
  output logic [CNT_W-1:0]  wr_full
);
  localparam int DESC_BYTES = 8;
  localparam int BO_W = $clog2(BACKOFF + 1);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_FWAIT, S_BURST, S_BWAIT, S_BACK} st_t;

  st_t               st;
  logic              ret_fetch, eot, dir;
  logic [31:0]       ptr, addr;
  logic [DCNT_W-1:0] left;
  logic [CMD_W-1:0]  cmd_left;
  logic [BO_W-1:0]   bo;
  logic [LEN_W-1:0]  room, chunk;

  assign room     = LEN_W'(PAGE_BYTES) - LEN_W'(addr[PG_W-1:0]);
  assign chunk    = ((DCNT_W+1)'(left) < (DCNT_W+1)'(room)) ? LEN_W'(left) : room;
  assign mem_desc = (st == S_FETCH);
  assign mem_req  = (st == S_FETCH || st == S_BURST) && !mem_busy;
  assign mem_we   = dir && !mem_desc;
  assign mem_addr = mem_desc ? ptr : addr;
  assign mem_len  = mem_desc ? LEN_W'(DESC_BYTES) : chunk;
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ret_fetch <= 1'b0;
      eot <= 1'b0;
      dir <= 1'b0;
      ptr <= '0;
      addr <= '0;
      left <= '0;
      cmd_left <= '0;
      bo <= '0;
      done <= 1'b0;
      err <= 1'b0;
      start_ign <= 1'b0;
      rd_txn <= '0;
      rd_bytes <= '0;
      rd_full <= '0;
      wr_txn <= '0;
      wr_bytes <= '0;
      wr_full <= '0;
    end else begin
      done <= 1'b0;
      err <= 1'b0;
      start_ign <= start && busy;
      if (abort && busy) begin
        err <= 1'b1;
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            ptr <= tbl_base & ~32'h3;
            cmd_left <= cmd_bytes;
            dir <= to_mem;
            st <= S_FETCH;
          end
          S_FETCH: if (mem_busy) begin
            bo <= BO_W'(BACKOFF - 1);
            ret_fetch <= 1'b1;
            st <= S_BACK;
          end else st <= S_FWAIT;
          S_FWAIT: if (mem_ack) begin
            addr <= dsc_base;
            left <= dsc_count;
            eot <= dsc_eot;
            ptr <= ptr + 32'(DESC_BYTES);
            if (dsc_count != '0) st <= S_BURST;
            else if (!dsc_eot) st <= S_FETCH;
            else begin
              st <= S_IDLE;
              done <= (cmd_left == '0);
              err <= (cmd_left != '0);
            end
          end
          S_BURST: if (mem_busy) begin
            bo <= BO_W'(BACKOFF - 1);
            ret_fetch <= 1'b0;
            st <= S_BACK;
          end else st <= S_BWAIT;
          S_BWAIT: if (mem_ack) begin
            addr <= addr + 32'(chunk);
            left <= left - DCNT_W'(chunk);
            cmd_left <= cmd_left - CMD_W'(chunk);
            if (dir) begin
              wr_txn <= wr_txn + 1'b1;
              wr_bytes <= wr_bytes + CNT_W'(chunk);
              if (chunk == LEN_W'(PAGE_BYTES)) wr_full <= wr_full + 1'b1;
            end else begin
              rd_txn <= rd_txn + 1'b1;
              rd_bytes <= rd_bytes + CNT_W'(chunk);
              if (chunk == LEN_W'(PAGE_BYTES)) rd_full <= rd_full + 1'b1;
            end
            if (left != DCNT_W'(chunk)) st <= S_BURST;
            else if (!eot) st <= S_FETCH;
            else begin
              st <= S_IDLE;
              done <= (cmd_left == CMD_W'(chunk));
              err <= (cmd_left != CMD_W'(chunk));
            end
          end
          S_BACK: if (bo == '0) st <= ret_fetch ? S_FETCH : S_BURST;
                  else bo <= bo - 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/prd_dma_chk.sv
module prd_dma_chk #(
  parameter int PAGE_BYTES = 4096,
  parameter int LEN_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             abort,
  input logic             mem_req,
  input logic             mem_desc,
  input logic [31:0]      mem_addr,
  input logic [LEN_W-1:0] mem_len,
  input logic             mem_busy,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             start_ign
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  // R6
  no_req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !mem_busy);
  // R6
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req);
  // R4
  page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_desc) |-> (33'(mem_addr[PG_W-1:0]) + 33'(mem_len) <= 33'(PAGE_BYTES)));
  // R12
  nonzero_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_desc) |-> (mem_len != '0));
  // R2
  desc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_desc) |-> (mem_addr[1:0] == 2'b00 && mem_len == LEN_W'(8)));
  // R7
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (!busy && !(done && err)));
  // R9
  abort_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy) |=> (err && !busy));
  // R11
  ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ign |-> ($past(start) && $past(busy)));
endmodule

bind prd_dma_engine prd_dma_chk #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .mem_req(mem_req),
  .mem_desc(mem_desc), .mem_addr(mem_addr), .mem_len(mem_len), .mem_busy(mem_busy),
  .busy(busy), .done(done), .err(err), .start_ign(start_ign)
);

// File: tb/tb_prd_dma_engine.sv
module tb_prd_dma_engine;
  localparam int PAGE = 4096;
  localparam int BACKOFF = 4;
  localparam int LEN_W = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, to_mem = 0, abort = 0, mem_busy = 0, mem_ack = 0;
  logic [31:0] tbl_base = 0;
  logic [17:0] cmd_bytes = 0;
  logic mem_req, mem_we, mem_desc, busy, done, err, start_ign;
  logic [31:0] mem_addr, dsc_base;
  logic [LEN_W-1:0] mem_len;
  logic [15:0] dsc_count;
  logic dsc_eot;
  logic [31:0] rd_txn, rd_bytes, rd_full, wr_txn, wr_bytes, wr_full;

  always #5 clk = ~clk;

  prd_dma_engine #(.PAGE_BYTES(PAGE), .BACKOFF(BACKOFF)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base), .to_mem(to_mem),
    .cmd_bytes(cmd_bytes), .abort(abort), .mem_req(mem_req), .mem_we(mem_we),
    .mem_desc(mem_desc), .mem_addr(mem_addr), .mem_len(mem_len), .mem_busy(mem_busy),
    .mem_ack(mem_ack), .dsc_base(dsc_base), .dsc_count(dsc_count), .dsc_eot(dsc_eot),
    .busy(busy), .done(done), .err(err), .start_ign(start_ign),
    .rd_txn(rd_txn), .rd_bytes(rd_bytes), .rd_full(rd_full),
    .wr_txn(wr_txn), .wr_bytes(wr_bytes), .wr_full(wr_full));

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // descriptor table at 0x1000: {base, count, eot}
  logic [48:0] dmem [8];
  initial begin
    dmem[0] = {32'h0000_2000, 16'd512,  1'b1};
    dmem[1] = {32'h0000_2F00, 16'd768,  1'b0};
    dmem[2] = {32'h0001_0000, 16'd8192, 1'b1};
    dmem[3] = {32'h0000_5000, 16'd1024, 1'b1};
    dmem[4] = {32'h0000_7000, 16'd0,    1'b0};
    dmem[5] = {32'h0000_6010, 16'd16,   1'b1};
    dmem[6] = {32'h0, 16'd0, 1'b1};
    dmem[7] = {32'h0, 16'd0, 1'b1};
  end

  // memory model and request log
  logic [31:0] paddr = 0;
  logic pend = 0;
  int pcnt = 0, cyc = 0, lg_n = 0;
  logic [31:0] lg_addr [256];
  logic [LEN_W-1:0] lg_len [256];
  logic lg_we [256], lg_desc [256];
  int lg_cyc [256];

  always_comb begin
    logic [31:0] idx;
    idx = (paddr - 32'h1000) >> 3;
    if (idx < 8) {dsc_base, dsc_count, dsc_eot} = dmem[idx[2:0]];
    else {dsc_base, dsc_count, dsc_eot} = {32'h0, 16'h0, 1'b1};
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ack <= 1'b0;
    if (mem_req) begin
      lg_addr[lg_n[7:0]] <= mem_addr;
      lg_len[lg_n[7:0]] <= mem_len;
      lg_we[lg_n[7:0]] <= mem_we;
      lg_desc[lg_n[7:0]] <= mem_desc;
      lg_cyc[lg_n[7:0]] <= cyc;
      lg_n <= lg_n + 1;
      paddr <= mem_addr;
      pend <= 1'b1;
      pcnt <= 2;
    end else if (pend) begin
      if (pcnt == 0) begin mem_ack <= 1'b1; pend <= 1'b0; end
      else pcnt <= pcnt - 1;
    end
  end

  // {tbl, dir, cmd, exp_err, bursts, bytes, full}
  localparam int NV = 4;
  localparam logic [99:0] VEC [NV] = '{
    {32'h0000_1003, 1'b0, 18'd512,  1'b0, 8'd1, 32'd512,  8'd0},
    {32'h0000_1008, 1'b1, 18'd8960, 1'b0, 8'd4, 32'd8960, 8'd2},
    {32'h0000_1018, 1'b0, 18'd2048, 1'b1, 8'd1, 32'd1024, 8'd0},
    {32'h0000_1020, 1'b1, 18'd16,   1'b0, 8'd1, 32'd16,   8'd0}
  };

  int start_cyc = 0, lg0 = 0;
  bit got_err, got_done;

  task automatic kick(input logic [31:0] t, input logic d, input logic [17:0] c);
    @(negedge clk);
    tbl_base = t; to_mem = d; cmd_bytes = c; start = 1'b1;
    lg0 = lg_n; start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    got_err = 0; got_done = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done || err) begin got_done = done; got_err = err; break; end
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint e_rd_b = 0, e_wr_b = 0, e_rd_t = 0, e_wr_t = 0, e_rd_f = 0, e_wr_f = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !mem_req && !done && !err && !start_ign, "R1 idle", {busy, mem_req, done, err}, 0);
    check(rd_txn == 0 && rd_bytes == 0 && rd_full == 0 && wr_txn == 0 && wr_bytes == 0 && wr_full == 0,
          "R1 counters", rd_bytes + wr_bytes, 0);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] t; logic d; logic [17:0] c; logic xe; int nb, nbytes, nfull, kb;
      bit we_ok;
      {t, d, c, xe} = VEC[v][99:48];
      kick(t, d, c);
      wait_end();
      // R7 R8 completion kind
      check(got_err == xe && got_done == !xe, xe ? "R8 err at end" : "R7 done at end", got_err, xe);
      check(!busy, "R7 idle after end", busy, 0);
      // R2 first fetch address
      check(lg_desc[lg0[7:0]] && lg_addr[lg0[7:0]] == (t & ~32'h3), "R2 table base",
            lg_addr[lg0[7:0]], t & ~32'h3);
      nb = 0; nbytes = 0; nfull = 0; we_ok = 1; kb = 0;
      for (int i = lg0; i < lg_n; i++) begin
        if (!lg_desc[i[7:0]]) begin
          nb++; nbytes += int'(lg_len[i[7:0]]);
          if (lg_len[i[7:0]] == LEN_W'(PAGE)) nfull++;
          if (lg_we[i[7:0]] != d) we_ok = 0;
        end else if (lg_we[i[7:0]]) we_ok = 0;
      end
      // R4 R12 burst count, R3 bytes taken from descriptors
      check(nb == int'(VEC[v][47:40]), "R4 R12 burst count", nb, VEC[v][47:40]);
      check(nbytes == int'(VEC[v][39:8]), "R3 region bytes", nbytes, VEC[v][39:8]);
      check(we_ok, "R5 direction", we_ok, 1);
      if (d) begin e_wr_b += nbytes; e_wr_t += nb; e_wr_f += nfull; end
      else begin e_rd_b += nbytes; e_rd_t += nb; e_rd_f += nfull; end
      check(nfull == int'(VEC[v][7:0]), "R10 full-page bursts", nfull, VEC[v][7:0]);
      // R10 counters
      check(rd_bytes == e_rd_b && wr_bytes == e_wr_b, "R10 byte counters", rd_bytes + wr_bytes, e_rd_b + e_wr_b);
      check(rd_txn == e_rd_t && wr_txn == e_wr_t && rd_full == e_rd_f && wr_full == e_wr_f,
            "R10 txn counters", rd_txn + wr_txn, e_rd_t + e_wr_t);
      if (v == 1) begin
        // R4 chunk split across page boundary; R2 second fetch at +8
        for (int i = lg0; i < lg_n; i++) if (!lg_desc[i[7:0]]) begin
          if (kb == 0) check(lg_addr[i[7:0]] == 32'h2F00 && lg_len[i[7:0]] == 256, "R4 first chunk",
                             lg_len[i[7:0]], 256);
          if (kb == 1) check(lg_addr[i[7:0]] == 32'h3000 && lg_len[i[7:0]] == 512, "R4 second chunk",
                             lg_len[i[7:0]], 512);
          if (kb == 2) check(lg_addr[i[7:0]] == 32'h1_0000 && lg_len[i[7:0]] == 4096, "R4 full page",
                             lg_len[i[7:0]], 4096);
          kb++;
        end else if (i > lg0) check(lg_addr[i[7:0]] == 32'h1010, "R2 pointer advance", lg_addr[i[7:0]], 32'h1010);
      end
      if (v == 3) check(lg_addr[(lg0 + 2) % 256] == 32'h6010, "R12 empty entry skipped",
                        lg_addr[(lg0 + 2) % 256], 32'h6010);
      repeat (5) @(negedge clk);
    end

    // R6 back-off timing
    @(negedge clk);
    mem_busy = 1'b1;
    tbl_base = 32'h1000; to_mem = 0; cmd_bytes = 512; start = 1'b1;
    lg0 = lg_n; start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    mem_busy = 1'b0;
    wait_end();
    check(got_done, "R6 done after back-off", got_done, 1);
    check(lg_cyc[lg0[7:0]] == start_cyc + BACKOFF + 2, "R6 retry time",
          lg_cyc[lg0[7:0]] - start_cyc, BACKOFF + 2);
    e_rd_b += 512;
    repeat (5) @(negedge clk);

    // R11 start while busy
    kick(32'h1000, 1'b0, 18'd512);
    tbl_base = 32'h1020; to_mem = 1; cmd_bytes = 16; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(start_ign, "R11 ignored flag", start_ign, 1);
    wait_end();
    e_rd_b += 512;
    check(got_done && rd_bytes == e_rd_b && wr_bytes == e_wr_b, "R11 transfer unchanged",
          rd_bytes, e_rd_b);
    repeat (5) @(negedge clk);

    // R9 abort mid-transfer
    kick(32'h1008, 1'b1, 18'd8960);
    repeat (12) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(err && !done, "R9 abort error", err, 1);
    check(!busy, "R9 idle after abort", busy, 0);
    repeat (10) @(negedge clk);
    check(!busy && !mem_req, "R9 stays idle", busy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule